// File: doc/BRIEF.md
# Remote DMA Data Port

This block sits between a host's single data-port address and the packet memory of a network controller. Each host access to the port moves one item of 1, 2 or 4 bytes between the host and the memory location named by an internal remote address pointer. After the access the pointer steps forward by the item size, and a remaining byte count steps down by the same amount. The pointer folds back to the receive-ring start when it lands exactly on the ring stop. When the count runs out, the block saturates it at zero and sends a one-cycle completion strobe to the interrupt logic.

The packet memory is held inside the block. It has a 32-byte identity area that is seeded from the station address at reset, and a packet RAM window set by parameters. Any byte outside these two regions is unmapped. A write to an unmapped byte is dropped, and a read of one returns 0xFF in that byte lane. Register programming happens elsewhere. The pointer and the count are loaded through strobed inputs, and the ring bounds and the 16-bit mode arrive as plain inputs.

A small state machine sequences every access. From ST_IDLE it takes one of three paths. A read goes to ST_RD_FETCH, then to ST_RD_RESP, then back to ST_IDLE. A write with a count that is not zero goes to ST_WR_COMMIT and then back to ST_IDLE. A write with the count at zero goes to ST_WR_SKIP and then back to ST_IDLE. All of these transitions take one cycle each and need no condition except the first choice made in ST_IDLE.

Top module: `rdma_port`

## Requirements
- R1: The item size is 4 bytes when `acc_dword` is 1. Otherwise it is 2 bytes when `cfg_word` is 1 and 1 byte when `cfg_word` is 0. The pointer advances by the item size on every access that is accepted and not skipped.
- R2: If the advanced pointer equals `ring_stop`, the pointer takes `ring_start` instead.
- R3: If the count is less than or equal to the item size, the count becomes 0 and `dma_done` is high for exactly one cycle, the cycle after acceptance. Otherwise the count drops by the item size and `dma_done` stays low.
- R4: A write accepted while the count is 0 changes no memory byte, leaves the pointer and the count unchanged, and raises no `dma_done`.
- R5: A read accepted while the count is 0 still returns data and advances the pointer, and it raises `dma_done`.
- R6: For 2-byte and 4-byte items, the memory address is the pointer with bit 0 cleared. The pointer itself still advances from its unaligned value. Data is little-endian: the lowest address maps to bits 7:0.
- R7: Each byte lane is checked on its own. A byte is mapped only below address 32 or within [PMEM_START, PMEM_END). An unmapped write lane is dropped, and an unmapped read lane returns 0xFF. Lanes above the item size read as 0x00.
- R8: After reset, identity byte 2k and identity byte 2k+1 both hold pattern byte k. Pattern bytes 0 to 5 are `station_addr` bytes 0 to 5, where byte 0 is bits 7:0. Pattern bytes 14 and 15 are 0x57. All other pattern bytes are 0x00.
- R9: A read accepted at one clock edge presents `rd_valid` and `rd_data` for one cycle, starting after the next edge. `acc_ready` is low from acceptance until the access ends.
- R10: A load strobe in the same cycle as acceptance takes precedence over the step for that register. The access itself uses the old pointer.
- R11: After reset the pointer is 0, the count is 0, `acc_ready` is 1, and `dma_done` and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| station_addr | input | 48 | Station address that seeds the identity area (byte 0 in bits 7:0) |
| cfg_word | input | 1 | Selects 2-byte items instead of 1-byte items for port accesses |
| ring_start | input | AW | Address the pointer wraps to |
| ring_stop | input | AW | Address that triggers the wrap |
| ld_addr_en | input | 1 | Strobe that loads the pointer |
| ld_addr | input | AW | Pointer load value |
| ld_cnt_en | input | 1 | Strobe that loads the count |
| ld_cnt | input | CW | Count load value |
| acc_req | input | 1 | Host access request, taken when `acc_ready` is 1 |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_dword | input | 1 | 4-byte access |
| acc_wdata | input | DW | Write data |
| acc_ready | output | 1 | Port is idle and can accept an access |
| rd_valid | output | 1 | Read data is valid |
| rd_data | output | DW | Read data |
| cur_addr | output | AW | Current pointer |
| cur_cnt | output | CW | Remaining count |
| dma_done | output | 1 | One-cycle completion strobe |

## Verification
The wrap back to the ring start and the count reaching zero can both happen on the same transfer. The bench sets this up by placing the pointer two bytes below a lowered ring stop, with the count at 2, and then writing a 2-byte item. In the cycle after acceptance it checks that the pointer equals the ring start, the count is zero and `dma_done` is high. A pointer load in the same cycle as a read is checked the same way: the read data must come from the old location, and the pointer must show the loaded value.

// File: rtl/rdp_pkg.sv
`timescale 1ns/1ps
package rdp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_COMMIT,
        ST_WR_SKIP,
        ST_RD_FETCH,
        ST_RD_RESP
    } rdp_state_e;

    typedef logic [2:0] item_len_t;

    function automatic item_len_t item_len(input logic dword, input logic word);
        if (dword)     return 3'd4;
        else if (word) return 3'd2;
        else           return 3'd1;
    endfunction

endpackage

// File: rtl/rdp_step.sv
`timescale 1ns/1ps
module rdp_step #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [CW-1:0] cur_cnt,
    input  logic [2:0]    len,
    input  logic [AW-1:0] ring_start,
    input  logic [AW-1:0] ring_stop,
    output logic [AW-1:0] nxt_addr,
    output logic [CW-1:0] nxt_cnt,
    output logic          finish
);
    logic [AW-1:0] sum;

    always_comb begin
        sum      = cur_addr + AW'(len);
        nxt_addr = (sum == ring_stop) ? ring_start : sum;
        finish   = (cur_cnt <= CW'(len));
        nxt_cnt  = finish ? '0 : (cur_cnt - CW'(len));
    end
endmodule

// File: rtl/rdp_fsm.sv
`timescale 1ns/1ps
module rdp_fsm
    import rdp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acc_req,
    input  logic acc_write,
    input  logic cnt_zero,
    output logic acc_ready,
    output logic accept,
    output logic skip,
    output logic mem_wen,
    output logic mem_ren,
    output logic rd_valid
);
    rdp_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_req) begin
                    if (!acc_write)    state_d = ST_RD_FETCH;
                    else if (cnt_zero) state_d = ST_WR_SKIP;
                    else               state_d = ST_WR_COMMIT;
                end
            end
            ST_WR_COMMIT: state_d = ST_IDLE;
            ST_WR_SKIP:   state_d = ST_IDLE;
            ST_RD_FETCH:  state_d = ST_RD_RESP;
            ST_RD_RESP:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        acc_ready = 1'b0;
        accept    = 1'b0;
        skip      = 1'b0;
        mem_wen   = 1'b0;
        mem_ren   = 1'b0;
        rd_valid  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                acc_ready = 1'b1;
                accept    = acc_req;
                skip      = acc_req && acc_write && cnt_zero;
            end
            ST_WR_COMMIT: mem_wen  = 1'b1;
            ST_WR_SKIP:   ;
            ST_RD_FETCH:  mem_ren  = 1'b1;
            ST_RD_RESP:   rd_valid = 1'b1;
            default:      ;
        endcase
    end
endmodule

// File: rtl/rdp_mem.sv
`timescale 1ns/1ps
module rdp_mem #(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int PROM_BYTES = 32,
    parameter int PMEM_START = 64,
    parameter int PMEM_END   = 320
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [47:0]   station_addr,
    input  logic          wen,
    input  logic          ren,
    input  logic [AW-1:0] base,
    input  logic [2:0]    len,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int LANES     = DW / 8;
    localparam int RAM_BYTES = PMEM_END - PMEM_START;
    localparam int RAM_IW    = (RAM_BYTES > 1) ? $clog2(RAM_BYTES) : 1;
    localparam int PROM_IW   = (PROM_BYTES > 1) ? $clog2(PROM_BYTES) : 1;

    logic [AW-1:0]      lane_addr [LANES];
    logic [LANES-1:0]   lane_on;
    logic [LANES-1:0]   in_prom;
    logic [LANES-1:0]   in_ram;
    logic [RAM_IW-1:0]  ram_idx   [LANES];
    logic [PROM_IW-1:0] prom_idx  [LANES];

    logic [7:0] prom [PROM_BYTES];
    logic [7:0] ram  [RAM_BYTES];

    logic [PROM_BYTES-1:0] prom_we;
    logic [7:0]            prom_wd [PROM_BYTES];

    function automatic logic [7:0] prom_seed(input logic [47:0] sa, input int idx);
        int pair;
        pair = idx / 2;
        if (pair < 6)                   return sa[8*pair +: 8];
        else if (pair == 14 || pair == 15) return 8'h57;
        else                            return 8'h00;
    endfunction

    // Per-lane address decode and window check
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            lane_addr[k] = base + AW'(k);
            lane_on[k]   = (k < int'(len));
            in_prom[k]   = (lane_addr[k] < AW'(PROM_BYTES));
            in_ram[k]    = (lane_addr[k] >= AW'(PMEM_START)) && (lane_addr[k] < AW'(PMEM_END));
            ram_idx[k]   = RAM_IW'(lane_addr[k] - AW'(PMEM_START));
            prom_idx[k]  = lane_addr[k][PROM_IW-1:0];
        end
    end

    // Identity-area write steering
    always_comb begin
        prom_we = '0;
        for (int g = 0; g < PROM_BYTES; g++) prom_wd[g] = 8'h00;
        for (int k = 0; k < LANES; k++) begin
            if (wen && lane_on[k] && in_prom[k]) begin
                prom_we[prom_idx[k]] = 1'b1;
                prom_wd[prom_idx[k]] = wdata[8*k +: 8];
            end
        end
    end

    for (genvar g = 0; g < PROM_BYTES; g++) begin : g_prom
        always_ff @(posedge clk) begin
            if (!rst_n)          prom[g] <= prom_seed(station_addr, g);
            else if (prom_we[g]) prom[g] <= prom_wd[g];
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (wen && lane_on[k] && in_ram[k])
                ram[ram_idx[k]] <= wdata[8*k +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (ren) begin
            for (int k = 0; k < LANES; k++) begin
                if (!lane_on[k])     rdata[8*k +: 8] <= 8'h00;
                else if (in_prom[k]) rdata[8*k +: 8] <= prom[prom_idx[k]];
                else if (in_ram[k])  rdata[8*k +: 8] <= ram[ram_idx[k]];
                else                 rdata[8*k +: 8] <= 8'hFF;
            end
        end
    end
endmodule

// File: rtl/rdma_port.sv
`timescale 1ns/1ps
module rdma_port
    import rdp_pkg::*;
#(
    parameter int AW         = 16,
    parameter int CW         = 16,
    parameter int DW         = 32,
    parameter int PROM_BYTES = 32,
    parameter int PMEM_START = 64,
    parameter int PMEM_END   = 320
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [47:0]   station_addr,
    input  logic          cfg_word,
    input  logic [AW-1:0] ring_start,
    input  logic [AW-1:0] ring_stop,
    input  logic          ld_addr_en,
    input  logic [AW-1:0] ld_addr,
    input  logic          ld_cnt_en,
    input  logic [CW-1:0] ld_cnt,
    input  logic          acc_req,
    input  logic          acc_write,
    input  logic          acc_dword,
    input  logic [DW-1:0] acc_wdata,
    output logic          acc_ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_cnt,
    output logic          dma_done
);
    logic          accept, skip, mem_wen, mem_ren;
    item_len_t     len_now, lat_len;
    logic [AW-1:0] base_now, lat_base;
    logic [DW-1:0] lat_wdata;
    logic [AW-1:0] nxt_addr;
    logic [CW-1:0] nxt_cnt;
    logic          finish;

    assign len_now  = item_len(acc_dword, cfg_word);
    assign base_now = (len_now == 3'd1) ? cur_addr : {cur_addr[AW-1:1], 1'b0};

    rdp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_req   (acc_req),
        .acc_write (acc_write),
        .cnt_zero  (cur_cnt == '0),
        .acc_ready (acc_ready),
        .accept    (accept),
        .skip      (skip),
        .mem_wen   (mem_wen),
        .mem_ren   (mem_ren),
        .rd_valid  (rd_valid)
    );

    rdp_step #(.AW(AW), .CW(CW)) u_step (
        .cur_addr   (cur_addr),
        .cur_cnt    (cur_cnt),
        .len        (len_now),
        .ring_start (ring_start),
        .ring_stop  (ring_stop),
        .nxt_addr   (nxt_addr),
        .nxt_cnt    (nxt_cnt),
        .finish     (finish)
    );

    rdp_mem #(
        .AW(AW), .DW(DW), .PROM_BYTES(PROM_BYTES),
        .PMEM_START(PMEM_START), .PMEM_END(PMEM_END)
    ) u_mem (
        .clk          (clk),
        .rst_n        (rst_n),
        .station_addr (station_addr),
        .wen          (mem_wen),
        .ren          (mem_ren),
        .base         (lat_base),
        .len          (lat_len),
        .wdata        (lat_wdata),
        .rdata        (rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_cnt   <= '0;
            dma_done  <= 1'b0;
            lat_base  <= '0;
            lat_len   <= 3'd1;
            lat_wdata <= '0;
        end else begin
            if (ld_addr_en)          cur_addr <= ld_addr;
            else if (accept && !skip) cur_addr <= nxt_addr;

            if (ld_cnt_en)           cur_cnt <= ld_cnt;
            else if (accept && !skip) cur_cnt <= nxt_cnt;

            dma_done <= accept && !skip && finish;

            if (accept) begin
                lat_base  <= base_now;
                lat_len   <= len_now;
                lat_wdata <= acc_wdata;
            end
        end
    end
endmodule

// File: rtl/rdma_port_chk.sv
`timescale 1ns/1ps
module rdma_port_chk #(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_word,
    input logic [AW-1:0] ring_start,
    input logic [AW-1:0] ring_stop,
    input logic          ld_addr_en,
    input logic          ld_cnt_en,
    input logic          acc_req,
    input logic          acc_write,
    input logic          acc_dword,
    input logic          acc_ready,
    input logic          rd_valid,
    input logic [AW-1:0] cur_addr,
    input logic [CW-1:0] cur_cnt,
    input logic          dma_done
);
    AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_ready && !acc_write && !acc_dword && !cfg_word && !ld_addr_en
        && ((cur_addr + AW'(1)) != ring_stop)
        |=> cur_addr == $past(cur_addr) + AW'(1)); // R1

    AST_NEVER_PARK_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_ready && !ld_addr_en && !(acc_write && cur_cnt == '0)
        && (ring_start != ring_stop)
        |=> cur_addr != $past(ring_stop)); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done |=> !dma_done); // R3

    AST_DONE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done && !$past(ld_cnt_en) |-> cur_cnt == '0); // R3

    AST_ZERO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_ready && acc_write && (cur_cnt == '0) && !ld_addr_en && !ld_cnt_en
        |=> $stable(cur_addr) && (cur_cnt == '0) && !dma_done); // R4

    AST_READ_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_ready && !acc_write |=> !acc_ready ##1 rd_valid); // R9

    AST_RDVALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !acc_ready); // R9

    AST_RDVALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid && acc_ready); // R9
endmodule

bind rdma_port rdma_port_chk #(.AW(AW), .CW(CW), .DW(DW)) chk_i (.*);

// File: tb/rdma_port_tb_top.sv
`timescale 1ns/1ps
module rdma_port_tb_top;
    localparam int AW = 16;
    localparam int CW = 16;
    localparam int DW = 32;
    localparam logic [47:0] STA = 48'h665544332211;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_word = 1'b0;
    logic [AW-1:0] ring_start = 16'h0040;
    logic [AW-1:0] ring_stop  = 16'h0140;
    logic          ld_addr_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic          ld_cnt_en = 1'b0;
    logic [CW-1:0] ld_cnt = '0;
    logic          acc_req = 1'b0;
    logic          acc_write = 1'b0;
    logic          acc_dword = 1'b0;
    logic [DW-1:0] acc_wdata = '0;
    logic          acc_ready, rd_valid, dma_done;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] cur_cnt;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    rdma_port dut_i (
        .clk(clk), .rst_n(rst_n), .station_addr(STA), .cfg_word(cfg_word),
        .ring_start(ring_start), .ring_stop(ring_stop),
        .ld_addr_en(ld_addr_en), .ld_addr(ld_addr), .ld_cnt_en(ld_cnt_en), .ld_cnt(ld_cnt),
        .acc_req(acc_req), .acc_write(acc_write), .acc_dword(acc_dword), .acc_wdata(acc_wdata),
        .acc_ready(acc_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .cur_addr(cur_addr), .cur_cnt(cur_cnt), .dma_done(dma_done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_addr(input logic [AW-1:0] v);
        @(negedge clk); ld_addr_en = 1'b1; ld_addr = v;
        @(negedge clk); ld_addr_en = 1'b0;
    endtask

    task automatic load_cnt(input logic [CW-1:0] v);
        @(negedge clk); ld_cnt_en = 1'b1; ld_cnt = v;
        @(negedge clk); ld_cnt_en = 1'b0;
    endtask

    // One port access; samples pointer, count and strobe in the cycle after acceptance.
    task automatic access(input bit wr, input bit dw, input bit wd, input logic [31:0] data,
                          input bit ld_same, input logic [AW-1:0] ld_val,
                          output logic [31:0] rdat, output logic [AW-1:0] a_seen,
                          output logic [CW-1:0] c_seen, output bit d_seen);
        @(negedge clk);
        cfg_word = wd; acc_write = wr; acc_dword = dw; acc_wdata = data; acc_req = 1'b1;
        if (ld_same) begin ld_addr_en = 1'b1; ld_addr = ld_val; end
        @(posedge clk);
        @(negedge clk);
        acc_req = 1'b0; ld_addr_en = 1'b0;
        a_seen = cur_addr; c_seen = cur_cnt; d_seen = dma_done;
        check(acc_ready == 1'b0, "R9 busy after accept", 32'(acc_ready), 32'h0);
        rdat = '0;
        if (!wr) begin
            @(posedge clk);
            @(negedge clk);
            check(rd_valid == 1'b1, "R9 rd_valid", 32'(rd_valid), 32'h1);
            rdat = rd_data;
        end
    endtask

    // Vector: {op[1:0], dword, word, data[31:0], expected[31:0]}; op 0=write 1=read 2=load pointer
    localparam int NV = 23;
    localparam logic [67:0] VEC [NV] = '{
        {2'd2, 1'b0, 1'b0, 32'h0000_0040, 32'h0},
        {2'd0, 1'b0, 1'b0, 32'h0000_00A1, 32'h0},
        {2'd0, 1'b0, 1'b0, 32'h0000_00B2, 32'h0},
        {2'd0, 1'b0, 1'b1, 32'h0000_1234, 32'h0},
        {2'd0, 1'b1, 1'b0, 32'hDEAD_BEEF, 32'h0},
        {2'd2, 1'b0, 1'b0, 32'h0000_0040, 32'h0},
        {2'd1, 1'b0, 1'b0, 32'h0, 32'h0000_00A1},
        {2'd1, 1'b0, 1'b0, 32'h0, 32'h0000_00B2},
        {2'd1, 1'b0, 1'b1, 32'h0, 32'h0000_1234},
        {2'd1, 1'b1, 1'b0, 32'h0, 32'hDEAD_BEEF},
        {2'd2, 1'b0, 1'b0, 32'h0000_0041, 32'h0},
        {2'd1, 1'b0, 1'b1, 32'h0, 32'h0000_B2A1},
        {2'd1, 1'b0, 1'b0, 32'h0, 32'h0000_0012},
        {2'd2, 1'b0, 1'b0, 32'h0000_0001, 32'h0},
        {2'd1, 1'b0, 1'b0, 32'h0, 32'h0000_0011},
        {2'd1, 1'b0, 1'b1, 32'h0, 32'h0000_2222},
        {2'd2, 1'b0, 1'b0, 32'h0000_001C, 32'h0},
        {2'd1, 1'b1, 1'b0, 32'h0, 32'h5757_5757},
        {2'd2, 1'b0, 1'b0, 32'h0000_0020, 32'h0},
        {2'd1, 1'b0, 1'b1, 32'h0, 32'h0000_FFFF},
        {2'd1, 1'b1, 1'b0, 32'h0, 32'hFFFF_FFFF},
        {2'd1, 1'b0, 1'b0, 32'h0, 32'h0000_00FF},
        {2'd2, 1'b0, 1'b0, 32'h0000_003E, 32'h0}
    };

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0]   rdat;
        logic [AW-1:0] a_s, m_addr;
        logic [CW-1:0] c_s, m_cnt;
        bit            d_s, m_done;
        int            len;

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(cur_addr == '0, "R11 pointer", 32'(cur_addr), 32'h0);
        check(cur_cnt == '0, "R11 count", 32'(cur_cnt), 32'h0);
        check(acc_ready == 1'b1, "R11 ready", 32'(acc_ready), 32'h1);
        check(dma_done == 1'b0 && rd_valid == 1'b0, "R11 strobes",
              {30'h0, dma_done, rd_valid}, 32'h0);

        // Table walk: R1 R6 R7 R8 with a reference pointer/count model
        load_cnt(16'h0100);
        m_cnt = 16'h0100; m_addr = '0;
        for (int i = 0; i < NV; i++) begin
            logic [67:0] v;
            v = VEC[i];
            if (v[67:66] == 2'd2) begin
                load_addr(v[63:48] == '0 ? v[47:32] : v[47:32]);
                m_addr = v[47:32];
            end else begin
                len = v[65] ? 4 : (v[64] ? 2 : 1);
                access(v[67:66] == 2'd0, v[65], v[64], v[63:32], 1'b0, '0, rdat, a_s, c_s, d_s);
                m_done = (m_cnt <= CW'(len));
                m_addr = m_addr + AW'(len);
                if (m_addr == ring_stop) m_addr = ring_start;
                m_cnt  = m_done ? '0 : m_cnt - CW'(len);
                check(a_s == m_addr, "R1 pointer step", 32'(a_s), 32'(m_addr));
                check(c_s == m_cnt && d_s == m_done, "R3 count step",
                      {15'h0, d_s, c_s}, {15'h0, m_done, m_cnt});
                if (v[67:66] == 2'd1)
                    check(rdat == v[31:0], "R6 R7 R8 read data", rdat, v[31:0]);
            end
        end
        // Straddling read at 0x3E: two unmapped lanes then 0x40,0x41 (R7)
        access(1'b0, 1'b1, 1'b0, '0, 1'b0, '0, rdat, a_s, c_s, d_s);
        check(rdat == 32'hB2A1_FFFF, "R7 per-lane window", rdat, 32'hB2A1_FFFF);

        // R2 + R3: wrap and completion on the same transfer
        ring_stop = 16'h0050;
        load_addr(16'h004E); load_cnt(16'd2);
        access(1'b1, 1'b0, 1'b1, 32'h0000_5566, 1'b0, '0, rdat, a_s, c_s, d_s);
        check(a_s == 16'h0040, "R2 wrap to start", 32'(a_s), 32'h40);
        check(c_s == '0 && d_s, "R3 done with wrap", {15'h0, d_s, c_s}, 32'h0001_0000);
        ring_stop = 16'h0140;

        // R3 saturation below item size, and single-cycle strobe
        load_addr(16'h0080); load_cnt(16'd1);
        access(1'b1, 1'b0, 1'b1, 32'h0000_0102, 1'b0, '0, rdat, a_s, c_s, d_s);
        check(c_s == '0 && d_s && a_s == 16'h0082, "R3 saturate",
              {d_s, 15'h0, c_s}, 32'h8000_0000);
        @(negedge clk);
        check(dma_done == 1'b0, "R3 strobe one cycle", 32'(dma_done), 32'h0);

        // R4: write at zero count ignored; R5: read at zero count served
        load_addr(16'h0060); load_cnt(16'd1);
        access(1'b1, 1'b0, 1'b0, 32'h33, 1'b0, '0, rdat, a_s, c_s, d_s);
        load_addr(16'h0060);
        access(1'b1, 1'b0, 1'b0, 32'h77, 1'b0, '0, rdat, a_s, c_s, d_s);
        check(a_s == 16'h0060 && c_s == '0 && !d_s, "R4 write ignored",
              {a_s, 7'h0, d_s, c_s[7:0]}, 32'h0060_0000);
        load_addr(16'h0060);
        access(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, rdat, a_s, c_s, d_s);
        check(rdat == 32'h33, "R4 memory untouched", rdat, 32'h33);
        check(a_s == 16'h0061 && c_s == '0 && d_s, "R5 zero-count read",
              {a_s, 7'h0, d_s, c_s[7:0]}, 32'h0061_0100);

        // R7: write to unmapped byte dropped
        load_addr(16'h0030); load_cnt(16'd8);
        access(1'b1, 1'b0, 1'b0, 32'h5A, 1'b0, '0, rdat, a_s, c_s, d_s);
        load_addr(16'h0030);
        access(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, rdat, a_s, c_s, d_s);
        check(rdat == 32'hFF, "R7 unmapped write dropped", rdat, 32'hFF);

        // R10: pointer load in the acceptance cycle wins; read uses old pointer
        load_addr(16'h0040); load_cnt(16'h0010);
        access(1'b0, 1'b0, 1'b0, '0, 1'b1, 16'h0090, rdat, a_s, c_s, d_s);
        check(a_s == 16'h0090, "R10 load wins", 32'(a_s), 32'h90);
        check(c_s == 16'h000F, "R10 count still steps", 32'(c_s), 32'hF);
        check(rdat == 32'hA1, "R10 old pointer read", rdat, 32'hA1);

        @(negedge clk);
        check(acc_ready == 1'b1 && rd_valid == 1'b0, "R9 return to idle",
              {30'h0, acc_ready, rd_valid}, 32'h2);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule